// File: doc/BRIEF.md
# Software-Kicked Watchdog Timer

This block is a watchdog timer that firmware must keep alive. It sits on a simple 8-bit data bus and holds one write-only service register at a fixed address. A free-running count advances on every clock. A bus write to the service address with bit 0 equal to 0 sends the count back to zero. If firmware stops servicing the block, the count reaches its limit and the block raises a one-cycle expiry pulse for the chip's reset sequencer. The count then starts over, so a missing reset path cannot cause a continuous pulse train.

A read of the service address does not return the register. It returns a fixed constant byte. A build-time parameter can remove the whole watchdog function, and the timeout length is a parameter as well.

Top module: `wdg_clear_timer`

## Requirements
- R1: While `rst` is high, `wdg_expire` is low. After `rst` falls, with no servicing, the first expiry pulse appears exactly TIMEOUT clock edges after the last edge at which `rst` was sampled high.
- R2: A write (`bus_wr`=1) to address CLR_ADDR (default 0x03F0) with `bus_wdata` bit 0 equal to 0 restarts the count. The next expiry then comes exactly TIMEOUT edges after the edge that sampled the write, unless another restart comes first.
- R3: A write to CLR_ADDR with bit 0 equal to 1 has no effect on the timing. Bits 7..1 of any write to CLR_ADDR are ignored.
- R4: Writes to any address other than CLR_ADDR, and reads of any address, do not affect the timing.
- R5: Each expiry pulse lasts exactly one cycle. The count restarts from zero on that same edge, so with no servicing the pulses repeat every TIMEOUT cycles.
- R6: When `bus_rd` is 1 and `bus_addr` equals CLR_ADDR, `bus_rdata` is 0x02 (bit 1 set, all other bits 0). In every other case `bus_rdata` is 0x00. The data path is combinational.
- R7: With ENABLE=0, `wdg_expire` never rises, whatever the bus traffic. The read path still behaves as in R6.
- R8: If a servicing write is sampled on the edge at which the count would expire, the servicing write takes priority: no pulse is issued and the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (16) | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| wdg_expire | output | 1 | One-cycle timeout pulse to the reset sequencer |

## Verification
The bench builds two copies of the block, both with TIMEOUT=37. One has ENABLE=1 and the other ENABLE=0. The short timeout lets a random run of a few thousand cycles reach many expiries, restarts and restart-versus-expiry collisions. The full 2^14 default would allow only a handful in the same run. The disabled copy receives identical traffic, so every cycle also checks that it stays silent while its read path still answers.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int          BYTE_W     = 8;
    localparam int          KICK_BIT   = 0;
    localparam logic [7:0]  READ_CONST = 8'h02;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_KICK = 2'd1,
        CMD_HOLD = 2'd2
    } wdg_cmd_e;

    typedef struct packed {
        logic              hit;
        logic              wr;
        logic              rd;
        logic [BYTE_W-1:0] wdata;
    } wdg_access_t;

    function automatic wdg_cmd_e classify(input wdg_access_t acc);
        if (!(acc.hit && acc.wr)) begin
            return CMD_NONE;
        end
        return acc.wdata[KICK_BIT] ? CMD_HOLD : CMD_KICK;
    endfunction

endpackage

// File: rtl/wdg_decode.sv
module wdg_decode
    import wdg_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 16'h03F0
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output wdg_cmd_e          cmd,
    output logic [BYTE_W-1:0] rdata
);

    wdg_access_t acc;

    always_comb begin
        acc.hit   = (bus_addr == CLR_ADDR);
        acc.wr    = bus_wr;
        acc.rd    = bus_rd;
        acc.wdata = bus_wdata;
    end

    always_comb begin
        cmd = classify(acc);
    end

    always_comb begin
        rdata = (acc.rd && acc.hit) ? READ_CONST : '0;
    end

endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
#(
    parameter int TIMEOUT = 16384,
    parameter bit ENABLE  = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  wdg_cmd_e cmd,
    output logic     expire
);

    localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

    generate
        if (ENABLE) begin : g_live
            logic [CNT_W-1:0] cnt;
            logic             pulse;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt   <= '0;
                    pulse <= 1'b0;
                end else if (cmd == CMD_KICK) begin
                    cnt   <= '0;
                    pulse <= 1'b0;
                end else if (cnt == LAST) begin
                    cnt   <= '0;
                    pulse <= 1'b1;
                end else begin
                    cnt   <= cnt + 1'b1;
                    pulse <= 1'b0;
                end
            end

            assign expire = pulse;

            AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> (cnt == '0 && !expire)); // R1
            AST_KICK_RESTARTS: assert property (@(posedge clk) disable iff (rst)
                (cmd == CMD_KICK) |=> (cnt == '0 && !expire)); // R2
            AST_HOLD_ADVANCES: assert property (@(posedge clk) disable iff (rst)
                (cmd != CMD_KICK && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1)); // R3
            AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
                expire |=> !expire); // R5
            AST_EXPIRE_ON_LAST: assert property (@(posedge clk) disable iff (rst)
                (cmd != CMD_KICK && cnt == LAST) |=> (expire && cnt == '0)); // R5
            AST_KICK_WINS: assert property (@(posedge clk) disable iff (rst)
                (cmd == CMD_KICK && cnt == LAST) |=> !expire); // R8
        end else begin : g_off
            logic unused_inputs;
            assign unused_inputs = ^{clk, rst, cmd};
            assign expire = 1'b0;

            AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
                !expire); // R7
        end
    endgenerate

    initial begin
        AST_TIMEOUT_RANGE: assert (TIMEOUT >= 2); // R5
    end

endmodule

// File: rtl/wdg_clear_timer.sv
module wdg_clear_timer
    import wdg_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 16'h03F0,
    parameter int                TIMEOUT  = 16384,
    parameter bit                ENABLE   = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              wdg_expire
);

    wdg_cmd_e cmd;

    wdg_decode #(
        .ADDR_W   (ADDR_W),
        .CLR_ADDR (CLR_ADDR)
    ) u_decode (
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cmd       (cmd),
        .rdata     (bus_rdata)
    );

    wdg_core #(
        .TIMEOUT (TIMEOUT),
        .ENABLE  (ENABLE)
    ) u_core (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .expire (wdg_expire)
    );

    AST_READ_CONST: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == CLR_ADDR) |-> (bus_rdata == 8'h02)); // R6
    AST_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == 8'h00)); // R6
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !wdg_expire); // R1

endmodule

// File: tb/test_wdg_clear_timer.sv
module test_wdg_clear_timer;

    localparam int          AW   = 16;
    localparam logic [15:0] CA   = 16'h03F0;
    localparam int          TO   = 37;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  rdata_on, rdata_off;
    logic        exp_on, exp_off;

    int tests = 0;
    int fails = 0;
    int since = 0;
    bit model_pulse = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdg_clear_timer #(.ADDR_W(AW), .CLR_ADDR(CA), .TIMEOUT(TO), .ENABLE(1'b1)) i_wdg_clear_timer (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_on), .wdg_expire(exp_on));

    wdg_clear_timer #(.ADDR_W(AW), .CLR_ADDR(CA), .TIMEOUT(TO), .ENABLE(1'b0)) i_wdg_clear_timer_off (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_off), .wdg_expire(exp_off));

    function automatic logic [7:0] exp_rdata(input logic rd, input logic [15:0] a);
        return (rd && a == CA) ? 8'h02 : 8'h00;
    endfunction

    function automatic bit is_kick(input logic wr, input logic [15:0] a, input logic [7:0] d);
        return wr && (a == CA) && !d[0];
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
        end
    endtask

    // Drive one bus cycle at the falling edge, check read data, let the edge pass,
    // then check the expiry outputs against the bench model.
    task automatic step(input logic wr, input logic rd, input logic [15:0] a,
                        input logic [7:0] d, input string tag);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        #1;
        check("R6 read on", rdata_on, exp_rdata(rd, a));
        check("R7 read off", rdata_off, exp_rdata(rd, a));
        if (is_kick(wr, a, d)) begin
            since = 0;
            model_pulse = 1'b0;
        end else begin
            since++;
            model_pulse = (since == TO);
            if (model_pulse) since = 0;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, {7'b0, exp_on}, {7'b0, model_pulse});
        check("R7 disabled", {7'b0, exp_off}, 8'h00);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 16'h0000, 8'h00, tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset", {7'b0, exp_on}, 8'h00);
        rst = 1'b0;
        since = 0;
        // R1: first expiry TIMEOUT edges after reset; R5 repeat period
        idle(TO, "R1 first expiry");
        idle(TO, "R5 periodic expiry");
        idle(5, "R5 single pulse");
        // R2 + R3: kick with upper bits set still restarts
        step(1'b1, 1'b0, CA, 8'hFE, "R2 kick");
        idle(20, "R2 after kick");
        // R3: bit0=1 is no effect
        step(1'b1, 1'b1, CA, 8'h01, "R3 hold write");
        step(1'b1, 1'b0, CA, 8'hFF, "R3 hold write");
        // R4: other addresses ignored, including reads
        step(1'b1, 1'b1, 16'h03F1, 8'h00, "R4 other addr");
        step(1'b1, 1'b0, 16'h13F0, 8'h00, "R4 other addr");
        idle(TO, "R4 expiry kept");
        // R8: kick exactly when expiry is due
        while (since != TO - 1) step(1'b0, 1'b1, CA, 8'h00, "R6 idle read");
        step(1'b1, 1'b0, CA, 8'h00, "R8 kick wins");
        idle(TO, "R8 restart timing");
        // Random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [15:0] a;
            logic [7:0]  d;
            r = int'($urandom_range(0, 99));
            a = (r < 50) ? CA : 16'($urandom);
            d = 8'($urandom);
            if (r < 4) d[0] = 1'b0;
            else if (r < 50) d[0] = 1'b1;
            if (r < 4) step(1'b1, 1'b0, a, d, "R2 random kick");
            else if (r < 50) step(1'b1, 1'($urandom), a, d, "R3 random hold");
            else if (r < 70) step(1'b1, 1'($urandom), a, d, "R4 random other");
            else step(1'b0, 1'($urandom), a, d, "R5 random idle");
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule